// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is a small memory-mapped I/O port for a microcontroller-style register bus. It serves three bidirectional pins and a fourth pin that only takes input. Each bidirectional pin has the following control bits:

- a direction bit
- an output latch bit
- an analog-select bit
- pull-up, slew-limit and input-threshold bits, which go straight out to the pad as control signals

Software reads the synchronized pin levels through the port register and reads the latched output values through a separate latch register. A read-modify-write on the latch therefore never picks up the level on the pin.

The fourth pin has no direction bit and no latch bit. A static configuration input decides what it does. It can act as an active-low external reset request, and then its port bit reads as one. Otherwise it is a plain digital input. All pin inputs go through a synchronizer before any logic uses them. After reset every bidirectional pin is an analog input with its output driver off.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction and analog-select registers read all ones in their low three bits. The latch, pull-up, slew and threshold registers read zero. `pad_oe_o` is 0.
- R2: `pad_oe_o[i]` is the inverse of direction bit i: 1 at an address means input with the driver off. This holds whatever the analog-select bit is. `pad_out_o` equals the latch.
- R3: Port register (address 0) bit i, for i = 0 to 2, reads 0 while analog-select bit i (address 3) is set. Otherwise it reads the synchronized level of `pin_in_i[i]`.
- R4: The latch register (address 1) returns the latched values, not the pin levels.
- R5: A write to address 0 loads `wdata_i[2:0]` into the latch. Bit 3 and all higher bits of the write are ignored.
- R6: Port bit 3 reads 1 while `rst_pin_en_i` is 1. While it is 0, the bit reads the synchronized level of `aux_pin_i`.
- R7: A change on a pin input shows in the port register read data after exactly two rising clock edges.
- R8: Pull-up (address 4), slew-limit (address 5) and threshold (address 6) bits are independent per pin. Each drives its own pad output bit. A set slew bit means the pad is slew-limited.
- R9: Addresses 7 to 15 read 0, and writes to them change no register.
- R10: `ext_rst_o` is 1 exactly when `rst_pin_en_i` is 1 and the synchronized `aux_pin_i` is 0.
- R11: Bits above the pin bits of every register read 0, even after a write of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| we_i | input | 1 | Write enable, single cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pin_in_i | input | 3 | Pad input levels of the bidirectional pins |
| aux_pin_i | input | 1 | Input-only fourth pin |
| rst_pin_en_i | input | 1 | Static: fourth pin used as reset request |
| pad_oe_o | output | 3 | Output driver enables |
| pad_out_o | output | 3 | Output data from the latch |
| pad_ana_o | output | 3 | Analog-select to the pad |
| pad_pu_o | output | 3 | Weak pull-up enables |
| pad_slew_o | output | 3 | Slew-limit enables |
| pad_thr_o | output | 3 | Input-threshold select |
| ext_rst_o | output | 1 | Reset request from the fourth pin |

## Verification
Several relations are checked on every cycle:

- direction readback against the driver enables
- analog masking of port reads
- the forced one on bit 3
- the two-edge latency from pin to read data
- latch loading from port writes
- zero data from unmapped addresses
- the gating of the reset request

Some behaviour needs scenarios with specific stimulus, so only the bench's scenarios can show it:

- the reset values
- the separation of latch reads from conflicting pin levels
- the independence of each pad control bit
- ignored high write bits
- writes to unmapped addresses leaving every register unchanged

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 4'd0,
    REG_LAT  = 4'd1,
    REG_DIR  = 4'd2,
    REG_ANA  = 4'd3,
    REG_PUEN = 4'd4,
    REG_SLEW = 4'd5,
    REG_THR  = 4'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_BIDI = 3,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_BIDI-1:0] lat_o,
  output logic [NUM_BIDI-1:0] dir_o,
  output logic [NUM_BIDI-1:0] ana_o,
  output logic [NUM_BIDI-1:0] pu_o,
  output logic [NUM_BIDI-1:0] slew_o,
  output logic [NUM_BIDI-1:0] thr_o
);
  logic [NUM_BIDI-1:0] wbits;
  assign wbits = wdata_i[NUM_BIDI-1:0];

  // port and latch addresses both load the output latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_o  <= '0;
      dir_o  <= '1;
      ana_o  <= '1;
      pu_o   <= '0;
      slew_o <= '0;
      thr_o  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        REG_PORT, REG_LAT: lat_o  <= wbits;
        REG_DIR:           dir_o  <= wbits;
        REG_ANA:           ana_o  <= wbits;
        REG_PUEN:          pu_o   <= wbits;
        REG_SLEW:          slew_o <= wbits;
        REG_THR:           thr_o  <= wbits;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_BIDI = 3,
  parameter int unsigned DATA_W   = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_BIDI-1:0] pin_sync_i,
  input  logic                aux_sync_i,
  input  logic                rst_pin_en_i,
  input  logic [NUM_BIDI-1:0] lat_i,
  input  logic [NUM_BIDI-1:0] dir_i,
  input  logic [NUM_BIDI-1:0] ana_i,
  input  logic [NUM_BIDI-1:0] pu_i,
  input  logic [NUM_BIDI-1:0] slew_i,
  input  logic [NUM_BIDI-1:0] thr_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned AUX_BIT = NUM_BIDI;

  logic [NUM_BIDI-1:0] port_bits;
  logic                aux_bit;

  assign port_bits = pin_sync_i & ~ana_i;
  assign aux_bit   = rst_pin_en_i | aux_sync_i;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_PORT: begin
        rdata_o[NUM_BIDI-1:0] = port_bits;
        rdata_o[AUX_BIT]      = aux_bit;
      end
      REG_LAT:  rdata_o[NUM_BIDI-1:0] = lat_i;
      REG_DIR:  rdata_o[NUM_BIDI-1:0] = dir_i;
      REG_ANA:  rdata_o[NUM_BIDI-1:0] = ana_i;
      REG_PUEN: rdata_o[NUM_BIDI-1:0] = pu_i;
      REG_SLEW: rdata_o[NUM_BIDI-1:0] = slew_i;
      REG_THR:  rdata_o[NUM_BIDI-1:0] = thr_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_BIDI    = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_BIDI-1:0] pin_in_i,
  input  logic                aux_pin_i,
  input  logic                rst_pin_en_i,
  output logic [NUM_BIDI-1:0] pad_oe_o,
  output logic [NUM_BIDI-1:0] pad_out_o,
  output logic [NUM_BIDI-1:0] pad_ana_o,
  output logic [NUM_BIDI-1:0] pad_pu_o,
  output logic [NUM_BIDI-1:0] pad_slew_o,
  output logic [NUM_BIDI-1:0] pad_thr_o,
  output logic                ext_rst_o
);
  logic [NUM_BIDI-1:0] lat_q, dir_q, ana_q, pu_q, slew_q, thr_q;
  logic [NUM_BIDI-1:0] pin_sync;
  logic                aux_sync;

  gpio_sync #(.WIDTH(NUM_BIDI), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_in_i), .q_o(pin_sync)
  );

  // idle-high so a reset request does not fire straight out of reset
  gpio_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_aux_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(aux_pin_i), .q_o(aux_sync)
  );

  gpio_regs #(.NUM_BIDI(NUM_BIDI), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .lat_o(lat_q), .dir_o(dir_q), .ana_o(ana_q), .pu_o(pu_q), .slew_o(slew_q), .thr_o(thr_q)
  );

  gpio_rd_mux #(.NUM_BIDI(NUM_BIDI), .DATA_W(DATA_W)) u_rd_mux (
    .addr_i(addr_i), .pin_sync_i(pin_sync), .aux_sync_i(aux_sync),
    .rst_pin_en_i(rst_pin_en_i), .lat_i(lat_q), .dir_i(dir_q), .ana_i(ana_q),
    .pu_i(pu_q), .slew_i(slew_q), .thr_i(thr_q), .rdata_o(rdata_o)
  );

  assign pad_oe_o   = ~dir_q;
  assign pad_out_o  = lat_q;
  assign pad_ana_o  = ana_q;
  assign pad_pu_o   = pu_q;
  assign pad_slew_o = slew_q;
  assign pad_thr_o  = thr_q;
  assign ext_rst_o  = rst_pin_en_i & ~aux_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_BIDI    = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_BIDI-1:0] pin_in_i,
  input logic                aux_pin_i,
  input logic                rst_pin_en_i,
  input logic [NUM_BIDI-1:0] pad_oe_o,
  input logic [NUM_BIDI-1:0] pad_out_o,
  input logic [NUM_BIDI-1:0] pad_ana_o,
  input logic                ext_rst_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  a_r2_dir_vs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_DIR) |-> (rdata_o[NUM_BIDI-1:0] == ~pad_oe_o));

  a_r3_analog_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_PORT) |-> ((rdata_o[NUM_BIDI-1:0] & pad_ana_o) == '0));

  a_r5_port_write_loads_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_PORT) |=> (pad_out_o == $past(wdata_i[NUM_BIDI-1:0])));

  a_r6_aux_forced_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_PORT && rst_pin_en_i) |-> rdata_o[NUM_BIDI]);

  // two-stage latency only checked for the default depth
  a_r7_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SYNC_STAGES == 2 && cyc_q >= 2'd2 && addr_i == REG_PORT)
      |-> (rdata_o[NUM_BIDI-1:0] == ($past(pin_in_i, 2) & ~pad_ana_o)));

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > REG_THR) |-> (rdata_o == '0));

  a_r10_ext_rst_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_o |-> rst_pin_en_i);
endmodule

bind gpio_port gpio_port_chk #(
  .NUM_BIDI(NUM_BIDI), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .pin_in_i(pin_in_i), .aux_pin_i(aux_pin_i),
  .rst_pin_en_i(rst_pin_en_i), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o),
  .pad_ana_o(pad_ana_o), .ext_rst_o(ext_rst_o)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] pin_in_i = '0;
  logic       aux_pin_i = 1'b1;
  logic       rst_pin_en_i = 1'b0;
  logic [2:0] pad_oe_o, pad_out_o, pad_ana_o, pad_pu_o, pad_slew_o, pad_thr_o;
  logic       ext_rst_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  gpio_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pin_in_i(pin_in_i), .aux_pin_i(aux_pin_i),
    .rst_pin_en_i(rst_pin_en_i), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o),
    .pad_ana_o(pad_ana_o), .pad_pu_o(pad_pu_o), .pad_slew_o(pad_slew_o),
    .pad_thr_o(pad_thr_o), .ext_rst_o(ext_rst_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; #0.5;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd2, d); check("R1 dir", d, 8'h07);
    rd(4'd3, d); check("R1 ana", d, 8'h07);
    rd(4'd1, d); check("R1 lat", d, 8'h00);
    rd(4'd4, d); check("R1 pu", d, 8'h00);
    rd(4'd5, d); check("R1 slew", d, 8'h00);
    rd(4'd6, d); check("R1 thr", d, 8'h00);
    check("R1 oe", {5'd0, pad_oe_o}, 8'h00);
  endtask

  task automatic t_direction();
    wr(4'd2, 8'h05);
    #0.5 check("R2 oe", {5'd0, pad_oe_o}, 8'h02);
    wr(4'd1, 8'h06);
    #0.5 check("R2 out", {5'd0, pad_out_o}, 8'h06);
    // analog still set: driver follows direction
    check("R2 oe_analog", {5'd0, pad_oe_o}, 8'h02);
    wr(4'd2, 8'h07);
  endtask

  task automatic t_analog_read();
    logic [7:0] d;
    pin_in_i = 3'b111; settle();
    rd(4'd0, d); check("R3 all_analog", d & 8'h07, 8'h00);
    wr(4'd3, 8'h02); settle();
    rd(4'd0, d); check("R3 mixed", d & 8'h07, 8'h05);
    wr(4'd3, 8'h00);
    pin_in_i = 3'b010; settle();
    rd(4'd0, d); check("R3 digital", d & 8'h07, 8'h02);
  endtask

  task automatic t_latch_vs_pin();
    logic [7:0] d;
    wr(4'd2, 8'h00);
    wr(4'd1, 8'h05);
    pin_in_i = 3'b010; settle();
    rd(4'd1, d); check("R4 lat_read", d, 8'h05);
    rd(4'd0, d); check("R4 port_read", d & 8'h07, 8'h02);
  endtask

  task automatic t_port_write();
    logic [7:0] d;
    wr(4'd0, 8'hFB);
    rd(4'd1, d); check("R5 lat_from_port", d, 8'h03);
    #0.5 check("R5 pad_out", {5'd0, pad_out_o}, 8'h03);
    rst_pin_en_i = 1'b0; aux_pin_i = 1'b0; settle();
    rd(4'd0, d); check("R5 bit3_unwritten", d & 8'h08, 8'h00);
    aux_pin_i = 1'b1; settle();
  endtask

  task automatic t_sync_latency();
    logic [7:0] d;
    wr(4'd3, 8'h00);
    pin_in_i = 3'b000; settle();
    @(posedge clk_i); #1;
    pin_in_i = 3'b101;
    addr_i = 4'd0;
    @(posedge clk_i); #1;
    check("R7 after_one_edge", rdata_o & 8'h07, 8'h00);
    @(posedge clk_i); #1;
    check("R7 after_two_edges", rdata_o & 8'h07, 8'h05);
    d = rdata_o;
  endtask

  task automatic t_aux();
    logic [7:0] d;
    rst_pin_en_i = 1'b0; aux_pin_i = 1'b0; settle();
    rd(4'd0, d); check("R6 aux_low", d & 8'h08, 8'h00);
    check("R10 no_req_disabled", {7'd0, ext_rst_o}, 8'h00);
    aux_pin_i = 1'b1; settle();
    rd(4'd0, d); check("R6 aux_high", d & 8'h08, 8'h08);
    rst_pin_en_i = 1'b1; aux_pin_i = 1'b0; settle();
    rd(4'd0, d); check("R6 forced_one", d & 8'h08, 8'h08);
    check("R10 req_active", {7'd0, ext_rst_o}, 8'h01);
    aux_pin_i = 1'b1; settle();
    #0.5 check("R10 req_release", {7'd0, ext_rst_o}, 8'h00);
    rst_pin_en_i = 1'b0;
  endtask

  task automatic t_pad_ctrl();
    wr(4'd4, 8'h01);
    wr(4'd5, 8'h02);
    wr(4'd6, 8'h04);
    #0.5;
    check("R8 pu", {5'd0, pad_pu_o}, 8'h01);
    check("R8 slew", {5'd0, pad_slew_o}, 8'h02);
    check("R8 thr", {5'd0, pad_thr_o}, 8'h04);
    wr(4'd5, 8'h05);
    #0.5;
    check("R8 slew_indep", {5'd0, pad_slew_o}, 8'h05);
    check("R8 pu_kept", {5'd0, pad_pu_o}, 8'h01);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(4'd2, 8'hFF);
    rd(4'd2, d); check("R11 dir_high_bits", d, 8'h07);
    wr(4'd2, 8'h02);
    for (int a = 7; a < 16; a++) begin
      wr(a[3:0], 8'hFF);
      rd(a[3:0], d); check("R9 unmapped_read", d, 8'h00);
    end
    rd(4'd2, d); check("R9 dir_kept", d, 8'h02);
    rd(4'd1, d); check("R9 lat_kept", d, 8'h03);
    rd(4'd4, d); check("R9 pu_kept", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_direction();
    t_analog_read();
    t_latch_vs_pin();
    t_port_write();
    t_sync_latency();
    t_aux();
    t_pad_ctrl();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule